// File: doc/BRIEF.md
# First-Decisive-Event Run Classifier

This block watches a processor core while it runs a program and reduces the whole run to one outcome code. It takes event strobes from the core: an unsupported-opcode trap, a memory access tagged with its decoded region, a halt, and an instruction retire with its PC. For each event type it keeps the context of the first occurrence only. A trap keeps its PC and instruction word. An access to the unmapped region keeps its effective address and PC.

A trap, an unmapped access or a halt ends the run at once. If none of them occurs, a cycle watchdog ends the run. The outcome is then either a plain timeout or a bootstrap failure: nothing retired, or the programmed entry address was never retired. When the run ends, `done_o` pulses for one cycle. The outcome and the latched context stay frozen until the next reset.

All event inputs are plain single-cycle strobes, each with its context fields. They carry no back-pressure, because the block can always accept an event in the cycle it arrives. The entry address and the watchdog limit are control inputs that are held steady for the whole run.

Top module: `run_verdict_unit`

## Requirements
- R1: After reset, `outcome_o` is 0 (running), `done_o` is 0, `retire_cnt_o` is 0, and all four context outputs are 0.
- R2: A trap strobe sampled while running ends the run. After that clock edge, `outcome_o` is 1 and `done_o` is high, and the trap PC and instruction word appear on `trap_pc_o` and `trap_insn_o`.
- R3: An access strobe counts as unmapped only when `acc_region_i` equals `UNMAPPED_REGION` (default 7). It then ends the run with `outcome_o` = 2 and latches the address and PC on `miss_addr_o` and `miss_pc_o`. An access to any other region changes neither the outcome nor the context.
- R4: A halt strobe sampled while running ends the run with `outcome_o` = 3.
- R5: When several end conditions are present at the same edge, the outcome follows a fixed precedence: trap (1), then unmapped access (2), then halt (3), then watchdog.
- R6: Each context pair holds the values from the first event of its type. These are latched even if a higher-precedence event wins in the same cycle. No event after the run ends changes the context or the outcome.
- R7: The watchdog expires at the N-th clock edge after reset, where N is `wdog_limit_i`, or 1 if the limit is 0. If expiry ends the run and both a retire and a retire at `entry_addr_i` have been seen (counting that edge), `outcome_o` is 4.
- R8: At watchdog expiry, the outcome is 6 if no retire has been seen. It is 5 if there have been retires but none at the entry address.
- R9: `retire_cnt_o` counts the retire strobes sampled while running, including one sampled at the edge that ends the run. It saturates at its all-ones value and is frozen once the run ends.
- R10: `done_o` is high for exactly one cycle per run. After it, `outcome_o` holds its nonzero value until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, starts a new run |
| entry_addr_i | input | AW | Expected program entry address |
| wdog_limit_i | input | TW | Watchdog limit in clock cycles |
| trap_vld_i | input | 1 | Unsupported-opcode trap strobe |
| trap_pc_i | input | AW | PC of the trapping instruction |
| trap_insn_i | input | DW | Instruction word of the trapping instruction |
| acc_vld_i | input | 1 | Memory access strobe |
| acc_addr_i | input | AW | Effective address of the access |
| acc_pc_i | input | AW | PC of the accessing instruction |
| acc_region_i | input | RW | Decoded region code of the access |
| halt_i | input | 1 | Halt strobe |
| ret_vld_i | input | 1 | Instruction retire strobe |
| ret_pc_i | input | AW | PC of the retired instruction |
| done_o | output | 1 | One-cycle pulse when the run ends |
| outcome_o | output | 3 | Outcome code, 0 while running |
| trap_pc_o | output | AW | PC of the first trap |
| trap_insn_o | output | DW | Instruction word of the first trap |
| miss_addr_o | output | AW | Address of the first unmapped access |
| miss_pc_o | output | AW | PC of the first unmapped access |
| retire_cnt_o | output | CW | Saturating retire count |

## Verification
The assertions assume that every strobe and its context fields are sampled synchronously at the rising edge. They also assume that `entry_addr_i` and `wdog_limit_i` change only while reset is held, so the watchdog window and the entry match refer to one program per run. The bench drives all inputs at the falling edge, sets the limit and the entry address only during reset, and keeps the limits small so that every run ends by watchdog within a few dozen cycles. Random context values are driven even when the strobes are low. This shows that context is captured only on a qualifying strobe.

// File: rtl/rv_pkg.sv
package rv_pkg;

  typedef enum logic [2:0] {
    OC_RUN       = 3'd0,
    OC_TRAP      = 3'd1,
    OC_UNMAPPED  = 3'd2,
    OC_HALT      = 3'd3,
    OC_TIMEOUT   = 3'd4,
    OC_NO_ENTRY  = 3'd5,
    OC_NO_RETIRE = 3'd6
  } outcome_e;

  typedef struct packed {
    logic trap;
    logic unmapped;
    logic halt;
    logic expire;
  } end_req_t;

endpackage

// File: rtl/rv_first_capture.sv
module rv_first_capture #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         hit,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         seen
);

  logic         seen_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      data_q <= '0;
    end else if (arm && hit && !seen_q) begin
      seen_q <= 1'b1;
      data_q <= din;
    end
  end

  assign q    = data_q;
  assign seen = seen_q;

endmodule

// File: rtl/rv_retire_track.sv
module rv_retire_track #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ret_vld,
  input  logic [AW-1:0] ret_pc,
  input  logic [AW-1:0] entry_addr,
  output logic [CW-1:0] cnt,
  output logic          entry_nxt,
  output logic          any_nxt
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic          entry_q;
  logic          any_q;
  logic          at_entry;

  assign at_entry  = ret_vld && (ret_pc == entry_addr);
  assign entry_nxt = entry_q | at_entry;
  assign any_nxt   = any_q | ret_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      entry_q <= 1'b0;
      any_q   <= 1'b0;
    end else if (run) begin
      if (ret_vld && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      entry_q <= entry_nxt;
      any_q   <= any_nxt;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/rv_watchdog.sv
module rv_watchdog #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expire
);

  localparam logic [TW-1:0] TMR_MAX = '1;

  logic [TW-1:0] tmr_q;
  logic [TW:0]   edge_no;

  // Number of the edge about to be taken, counted from 1 after reset.
  assign edge_no = {1'b0, tmr_q} + {{TW{1'b0}}, 1'b1};
  assign expire  = run && (edge_no >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (run && (tmr_q != TMR_MAX)) begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

endmodule

// File: rtl/rv_verdict.sv
module rv_verdict
  import rv_pkg::*;
(
  input  end_req_t req,
  input  logic     entry_seen,
  input  logic     any_seen,
  output outcome_e code
);

  always_comb begin
    if (req.trap)          code = OC_TRAP;
    else if (req.unmapped) code = OC_UNMAPPED;
    else if (req.halt)     code = OC_HALT;
    else if (req.expire) begin
      if (!any_seen)        code = OC_NO_RETIRE;
      else if (!entry_seen) code = OC_NO_ENTRY;
      else                  code = OC_TIMEOUT;
    end else                code = OC_RUN;
  end

endmodule

// File: rtl/run_verdict_unit.sv
module run_verdict_unit
  import rv_pkg::*;
#(
  parameter int          AW              = 32,
  parameter int          DW              = 32,
  parameter int          RW              = 3,
  parameter int          CW              = 32,
  parameter int          TW              = 32,
  parameter logic [RW-1:0] UNMAPPED_REGION = 3'd7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] entry_addr_i,
  input  logic [TW-1:0] wdog_limit_i,
  input  logic          trap_vld_i,
  input  logic [AW-1:0] trap_pc_i,
  input  logic [DW-1:0] trap_insn_i,
  input  logic          acc_vld_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [AW-1:0] acc_pc_i,
  input  logic [RW-1:0] acc_region_i,
  input  logic          halt_i,
  input  logic          ret_vld_i,
  input  logic [AW-1:0] ret_pc_i,
  output logic          done_o,
  output logic [2:0]    outcome_o,
  output logic [AW-1:0] trap_pc_o,
  output logic [DW-1:0] trap_insn_o,
  output logic [AW-1:0] miss_addr_o,
  output logic [AW-1:0] miss_pc_o,
  output logic [CW-1:0] retire_cnt_o
);

  localparam int TRAP_W = AW + DW;
  localparam int MISS_W = 2 * AW;

  outcome_e outcome_q;
  logic     done_q;
  logic     run;
  logic     miss_hit;
  logic     expire;
  logic     entry_nxt;
  logic     any_nxt;
  end_req_t req;
  outcome_e code;

  logic [TRAP_W-1:0] trap_ctx;
  logic [MISS_W-1:0] miss_ctx;
  logic              trap_seen;
  logic              miss_seen;

  assign run      = (outcome_q == OC_RUN);
  assign miss_hit = acc_vld_i && (acc_region_i == UNMAPPED_REGION);

  rv_first_capture #(.W(TRAP_W)) u_trap_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (run),
    .hit  (trap_vld_i),
    .din  ({trap_pc_i, trap_insn_i}),
    .q    (trap_ctx),
    .seen (trap_seen)
  );

  rv_first_capture #(.W(MISS_W)) u_miss_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (run),
    .hit  (miss_hit),
    .din  ({acc_addr_i, acc_pc_i}),
    .q    (miss_ctx),
    .seen (miss_seen)
  );

  rv_retire_track #(.AW(AW), .CW(CW)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ret_vld   (ret_vld_i),
    .ret_pc    (ret_pc_i),
    .entry_addr(entry_addr_i),
    .cnt       (retire_cnt_o),
    .entry_nxt (entry_nxt),
    .any_nxt   (any_nxt)
  );

  rv_watchdog #(.TW(TW)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .limit (wdog_limit_i),
    .expire(expire)
  );

  always_comb begin
    req.trap     = run && trap_vld_i;
    req.unmapped = run && miss_hit;
    req.halt     = run && halt_i;
    req.expire   = expire;
  end

  rv_verdict u_verdict (
    .req       (req),
    .entry_seen(entry_nxt),
    .any_seen  (any_nxt),
    .code      (code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outcome_q <= OC_RUN;
      done_q    <= 1'b0;
    end else if (run && (code != OC_RUN)) begin
      outcome_q <= code;
      done_q    <= 1'b1;
    end else begin
      done_q    <= 1'b0;
    end
  end

  assign done_o      = done_q;
  assign outcome_o   = outcome_q;
  assign trap_pc_o   = trap_ctx[TRAP_W-1 -: AW];
  assign trap_insn_o = trap_ctx[DW-1:0];
  assign miss_addr_o = miss_ctx[MISS_W-1 -: AW];
  assign miss_pc_o   = miss_ctx[AW-1:0];

endmodule

// File: rtl/rv_checker.sv
module rv_checker #(
  parameter int            AW              = 32,
  parameter int            DW              = 32,
  parameter int            RW              = 3,
  parameter int            CW              = 32,
  parameter logic [RW-1:0] UNMAPPED_REGION = 3'd7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trap_vld_i,
  input logic          acc_vld_i,
  input logic [RW-1:0] acc_region_i,
  input logic          halt_i,
  input logic          done_o,
  input logic [2:0]    outcome_o,
  input logic [AW-1:0] trap_pc_o,
  input logic [DW-1:0] trap_insn_o,
  input logic [AW-1:0] miss_addr_o,
  input logic [AW-1:0] miss_pc_o,
  input logic [CW-1:0] retire_cnt_o
);

  // R1: reset state while held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert (retire_cnt_o == '0 || $past(rst_n))
        else $error("p_reset_count_r1");
    end
  end

  // R2, R5: a trap seen while running always decides the outcome
  p_trap_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_vld_i && outcome_o == 3'd0) |=> (outcome_o == 3'd1 && done_o));

  // R3, R5: unmapped access beats halt and watchdog
  p_miss_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld_i && acc_region_i == UNMAPPED_REGION && !trap_vld_i && outcome_o == 3'd0)
      |=> (outcome_o == 3'd2));

  // R4: halt beats watchdog
  p_halt_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !trap_vld_i && !(acc_vld_i && acc_region_i == UNMAPPED_REGION)
     && outcome_o == 3'd0) |=> (outcome_o == 3'd3));

  // R6: context frozen once the run is over
  p_ctx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome_o != 3'd0) |=> ($stable(trap_pc_o) && $stable(trap_insn_o)
                             && $stable(miss_addr_o) && $stable(miss_pc_o)));

  // R9: retire count frozen once the run is over
  p_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome_o != 3'd0) |=> $stable(retire_cnt_o));

  // R10: single-cycle done pulse, outcome held, done only with an outcome
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_outcome_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome_o != 3'd0) |=> $stable(outcome_o));

  p_done_coded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (outcome_o != 3'd0 && outcome_o != 3'd7));

endmodule

bind run_verdict_unit rv_checker #(
  .AW(AW), .DW(DW), .RW(RW), .CW(CW), .UNMAPPED_REGION(UNMAPPED_REGION)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trap_vld_i  (trap_vld_i),
  .acc_vld_i   (acc_vld_i),
  .acc_region_i(acc_region_i),
  .halt_i      (halt_i),
  .done_o      (done_o),
  .outcome_o   (outcome_o),
  .trap_pc_o   (trap_pc_o),
  .trap_insn_o (trap_insn_o),
  .miss_addr_o (miss_addr_o),
  .miss_pc_o   (miss_pc_o),
  .retire_cnt_o(retire_cnt_o)
);

// File: tb/sim_run_verdict_unit.sv
`timescale 1ns/1ps
module sim_run_verdict_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] entry_addr, wdog_limit;
  logic        trap_vld, acc_vld, halt, ret_vld;
  logic [31:0] trap_pc, trap_insn, acc_addr, acc_pc, ret_pc;
  logic [2:0]  acc_region;

  logic        done;
  logic [2:0]  outcome;
  logic [31:0] trap_pc_q, trap_insn_q, miss_addr_q, miss_pc_q, rcnt;

  logic        u1_done;
  logic [2:0]  u1_outcome;
  logic [31:0] u1_tpc, u1_tin, u1_ma, u1_mp;
  logic [3:0]  u1_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  run_verdict_unit u0 (
    .clk(clk), .rst_n(rst_n), .entry_addr_i(entry_addr), .wdog_limit_i(wdog_limit),
    .trap_vld_i(trap_vld), .trap_pc_i(trap_pc), .trap_insn_i(trap_insn),
    .acc_vld_i(acc_vld), .acc_addr_i(acc_addr), .acc_pc_i(acc_pc), .acc_region_i(acc_region),
    .halt_i(halt), .ret_vld_i(ret_vld), .ret_pc_i(ret_pc),
    .done_o(done), .outcome_o(outcome), .trap_pc_o(trap_pc_q), .trap_insn_o(trap_insn_q),
    .miss_addr_o(miss_addr_q), .miss_pc_o(miss_pc_q), .retire_cnt_o(rcnt));

  // Narrow counter copy for the saturation case (R9)
  run_verdict_unit #(.CW(4)) u1 (
    .clk(clk), .rst_n(rst_n), .entry_addr_i(entry_addr), .wdog_limit_i(wdog_limit),
    .trap_vld_i(trap_vld), .trap_pc_i(trap_pc), .trap_insn_i(trap_insn),
    .acc_vld_i(acc_vld), .acc_addr_i(acc_addr), .acc_pc_i(acc_pc), .acc_region_i(acc_region),
    .halt_i(halt), .ret_vld_i(ret_vld), .ret_pc_i(ret_pc),
    .done_o(u1_done), .outcome_o(u1_outcome), .trap_pc_o(u1_tpc), .trap_insn_o(u1_tin),
    .miss_addr_o(u1_ma), .miss_pc_o(u1_mp), .retire_cnt_o(u1_cnt));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] f_outcome(bit t, bit u, bit h, bit hit, bit any, bit ent);
    if (t) return 3'd1;
    if (u) return 3'd2;
    if (h) return 3'd3;
    if (hit) begin
      if (!any) return 3'd6;
      if (!ent) return 3'd5;
      return 3'd4;
    end
    return 3'd0;
  endfunction

  task automatic clear_strobes();
    trap_vld = 1'b0; acc_vld = 1'b0; halt = 1'b0; ret_vld = 1'b0;
  endtask

  task automatic run_trial(input int mode, input int lim, input logic [31:0] ent);
    logic [2:0]  m_out = 3'd0;
    longint      m_cnt = 0;
    bit          m_ent = 0, m_any = 0, t_seen = 0, u_seen = 0;
    logic [31:0] m_tpc = 0, m_tin = 0, m_ma = 0, m_mp = 0;
    int          eff = (lim == 0) ? 1 : lim;

    @(negedge clk);
    rst_n = 1'b0;
    clear_strobes();
    entry_addr = ent;
    wdog_limit = lim;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: state right after reset
    chk(outcome == 3'd0 && done == 1'b0, "R1", "outcome/done", {outcome, done}, 0);
    chk(rcnt == 0 && trap_pc_q == 0 && trap_insn_q == 0 && miss_addr_q == 0 && miss_pc_q == 0,
        "R1", "count/context", rcnt | trap_pc_q | miss_addr_q, 0);

    for (int n = 1; n <= eff; n++) begin
      bit t = 0, a = 0, h = 0, r = 0, u, hit, fin;
      logic [2:0] rg = 3'($urandom_range(0, 7));
      trap_pc = $urandom; trap_insn = $urandom; acc_addr = $urandom; acc_pc = $urandom;
      ret_pc = ent + 32'(4 * $urandom_range(1, 3));
      case (mode)
        0: begin
          t = ($urandom_range(0, 63) == 0);
          a = ($urandom_range(0, 7) == 0);
          h = ($urandom_range(0, 79) == 0);
          r = ($urandom_range(0, 1) == 0);
          if ($urandom_range(0, 3) == 0) ret_pc = ent;
        end
        1: begin
          r = ($urandom_range(0, 2) != 0);
          if ($urandom_range(0, 5) == 0) ret_pc = ent;
          a = ($urandom_range(0, 3) == 0);
          if (rg == 3'd7) rg = 3'd1;
        end
        2: ;
        3: r = 1;
        4: if (n == 3) begin t = 1; a = 1; h = 1; rg = 3'd7; r = 1; end
        5: if (n == 3) begin a = 1; h = 1; rg = 3'd7; end
        6: begin r = 1; if (n == 2) ret_pc = ent; h = (n == eff); end
        7: begin
          r = 1; a = 1; rg = 3'($urandom_range(0, 6));
          if (n == 1) ret_pc = ent;
        end
        default: begin r = 1; ret_pc = ent; end
      endcase
      trap_vld = t; acc_vld = a; acc_region = rg; halt = h; ret_vld = r;

      u   = a && (rg == 3'd7);
      hit = (n >= eff);
      m_any = m_any | r;
      m_ent = m_ent | (r && ret_pc == ent);
      if (r) m_cnt++;
      if (t && !t_seen) begin t_seen = 1; m_tpc = trap_pc; m_tin = trap_insn; end
      if (u && !u_seen) begin u_seen = 1; m_ma = acc_addr; m_mp = acc_pc; end
      m_out = f_outcome(t, u, h, hit, m_any, m_ent);
      fin = (m_out != 3'd0);

      @(negedge clk);
      chk(done == fin, "R10", "done pulse", done, fin);
      chk(outcome == m_out, "R5", "outcome", outcome, m_out);
      chk(rcnt == 32'(m_cnt), "R9", "retire count", rcnt, m_cnt);
      chk(u1_cnt == 4'((m_cnt > 15) ? 15 : m_cnt), "R9", "saturated count", u1_cnt,
          (m_cnt > 15) ? 15 : m_cnt);
      clear_strobes();
      if (fin) break;
    end

    // R6, R9, R10: events after the end change nothing
    for (int k = 0; k < 3; k++) begin
      trap_vld = 1; trap_pc = $urandom; trap_insn = $urandom;
      acc_vld = 1; acc_region = 3'd7; acc_addr = $urandom; acc_pc = $urandom;
      halt = 1; ret_vld = 1; ret_pc = ent;
      @(negedge clk);
      chk(done == 1'b0, "R10", "no second done", done, 0);
      chk(outcome == m_out, "R10", "outcome held", outcome, m_out);
      chk(rcnt == 32'(m_cnt), "R9", "count frozen", rcnt, m_cnt);
    end
    clear_strobes();
    chk(trap_pc_q == m_tpc && trap_insn_q == m_tin, "R6", "trap context",
        {trap_pc_q, trap_insn_q}, {m_tpc, m_tin});
    chk(miss_addr_q == m_ma && miss_pc_q == m_mp, "R6", "miss context",
        {miss_addr_q, miss_pc_q}, {m_ma, m_mp});
  endtask

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0;
    clear_strobes();
    entry_addr = 0; wdog_limit = 8;
    trap_pc = 0; trap_insn = 0; acc_addr = 0; acc_pc = 0; acc_region = 0; ret_pc = 0;

    run_trial(2, 0,  32'h8010_0008);  // R8: limit 0 acts as 1, no retires
    run_trial(2, 12, 32'h8010_0008);  // R8: no retires -> 6
    run_trial(3, 15, 32'h8010_0008);  // R8: retires but never entry -> 5
    run_trial(4, 20, 32'h0000_4000);  // R2, R5, R6: all events in one cycle
    run_trial(5, 20, 32'h0000_4000);  // R3, R4, R5: unmapped beats halt
    run_trial(6, 9,  32'h0000_4000);  // R4, R5: halt at the expiry edge
    run_trial(7, 25, 32'h0000_2000);  // R3, R7: mapped accesses ignored, timeout 4
    run_trial(8, 30, 32'h0000_1000);  // R9: narrow counter saturates
    for (int i = 0; i < 50; i++)
      run_trial((i % 3 == 0) ? 1 : 0, $urandom_range(10, 60), $urandom & 32'hFFFF_FFFC);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog run did not finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule